// File: doc/BRIEF.md
# Chained 2D DMA Transfer Engine

This engine copies memory word by word under the control of a linked list of control blocks held in memory. Software places one or more six-word blocks in memory, points the engine at the first one and pulses a start input. The engine reads each block, performs the copy it describes, and then follows the block's link to the next one. The chain ends when a link is zero or when the channel enable input is low at the moment the next block would be fetched.

A block copies either one linear run of 32-bit words or a rectangle of rows. In rectangle mode a signed 16-bit stride is added to each address between rows, separately for the source and the destination. Per-side flags decide whether an address advances by four bytes after each word, and whether the read or the write is skipped entirely. A skipped read supplies zero, so a fixed source with read-skip fills memory with zeros. A skipped write turns the block into a pure read sweep.

The engine has a single 32-bit master port with request/grant handshake and a separate read-response valid. It pulses an event for each finished block, a second event for blocks that ask for notification, and a third event when the chain stops. The live addresses, the visible length and the fetched block words are available as outputs for observation.

Top module: `cbdma_engine`

## Requirements
- R1: A block at address A is read as six words at A, A+4, A+8, A+12, A+16 and A+20, holding in that order: info, source address, destination address, length, stride and next-block address. Every request stays asserted with stable address, direction and data until `mem_gnt_i` is high. A read's data is taken only when `mem_rvalid_i` is high.
- R2: The info word is decoded at these bit positions: bit 0 notify, bit 1 rectangle mode, bit 4 destination advance, bit 7 destination skip, bit 8 source advance, bit 11 source skip.
- R3: In linear mode (info bit 1 clear) the block is one row whose byte count is the full length word. One word moves per 4 bytes, and a remainder below 4 bytes moves nothing.
- R4: In rectangle mode the row count is length bits [29:16] and the bytes per row are length bits [15:0]. After every row except the last, stride bits [15:0] are added to the source address and stride bits [31:16] to the destination address, both as signed 16-bit values. A row count of zero moves nothing.
- R5: With source skip set, no read is issued and the word written is zero. With destination skip set, no write is issued.
- R6: After each word, an address whose advance flag is set grows by 4, and an address whose flag is clear stays the same.
- R7: `cur_len_o` shows the fetched length word until the block's first word. After each word it shows {2'b0, rows left including the current row, bytes left in the row} in rectangle mode, and the bytes left in linear mode.
- R8: When a block completes, `blk_done_o` pulses for one cycle. `blk_irq_o` pulses with it only when info bit 0 is set. The next-block address then becomes `cur_blk_o`.
- R9: Before each block fetch, the engine continues only if `chan_en_i` is high and the current block address is nonzero. Otherwise `chain_done_o` pulses and the engine goes idle. A block that has started always finishes, even if `chan_en_i` drops during it.
- R10: A start with address zero, or with `chan_en_i` low, ends at once with `chain_done_o` and issues no memory request. A start pulse while busy is ignored.
- R11: After reset the engine is idle: `busy_o` and `mem_req_o` are low, and all observation outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| start_addr_i | input | 32 | Address of the first control block |
| chan_en_i | input | 1 | Channel enable, sampled before each block fetch |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Byte address of the request |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Engine not idle |
| blk_done_o | output | 1 | One-cycle pulse per finished block |
| blk_irq_o | output | 1 | Block-finished pulse for blocks with notify set |
| chain_done_o | output | 1 | One-cycle pulse when the chain stops |
| cur_blk_o | output | 32 | Current control-block address |
| cur_info_o | output | 32 | Fetched info word |
| cur_src_o | output | 32 | Live source address |
| cur_dst_o | output | 32 | Live destination address |
| cur_len_o | output | 32 | Visible remaining length |
| cur_stride_o | output | 32 | Fetched stride word |
| cur_next_o | output | 32 | Fetched next-block address |

## Verification
The hardest case to reach is a channel enable that falls while a block is in progress. The bench reaches it by waiting until the memory model has accepted the block's first write and then dropping the enable. It then expects the whole of that block and none of its successor. The same chain run also pulses start in mid-flight to show that a busy engine ignores it. Randomised grant and response delays from an LFSR in the memory model keep every request waiting for a varying number of cycles. Full sweeps cover the sixteen advance and skip combinations and the rectangle row counts 0 to 3 with positive and negative strides.

// File: rtl/cbdma_pkg.sv
package cbdma_pkg;
  localparam int WORD_W   = 32;
  localparam int CB_WORDS = 6;
  localparam int IDX_W    = $clog2(CB_WORDS);

  // Word positions inside a control block (fetch order).
  localparam int W_INFO   = 0;
  localparam int W_SRC    = 1;
  localparam int W_DST    = 2;
  localparam int W_LEN    = 3;
  localparam int W_STRIDE = 4;
  localparam int W_NEXT   = 5;

  // Info-word bit positions.
  localparam int B_NOTIFY = 0;
  localparam int B_RECT   = 1;
  localparam int B_DADV   = 4;
  localparam int B_DSKIP  = 7;
  localparam int B_SADV   = 8;
  localparam int B_SSKIP  = 11;

  typedef struct packed {
    logic src_skip;
    logic src_adv;
    logic dst_skip;
    logic dst_adv;
    logic rect;
    logic notify;
  } xinfo_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_FREQ, S_FWAIT, S_SETUP, S_ROW,
    S_RREQ, S_RWAIT, S_WREQ, S_STEP, S_BEND
  } eng_state_t;

  function automatic xinfo_t decode_info(input logic [WORD_W-1:0] w);
    xinfo_t f;
    f.src_skip = w[B_SSKIP];
    f.src_adv  = w[B_SADV];
    f.dst_skip = w[B_DSKIP];
    f.dst_adv  = w[B_DADV];
    f.rect     = w[B_RECT];
    f.notify   = w[B_NOTIFY];
    return f;
  endfunction
endpackage

// File: rtl/cbdma_cb_store.sv
module cbdma_cb_store
  import cbdma_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [W-1:0]     wr_data_i,
  output logic [W-1:0]     info_o,
  output logic [W-1:0]     src_o,
  output logic [W-1:0]     dst_o,
  output logic [W-1:0]     len_o,
  output logic [W-1:0]     stride_o,
  output logic [W-1:0]     next_o,
  output xinfo_t           flags_o
);
  logic [CB_WORDS-1:0][W-1:0] words;

  for (genvar g = 0; g < CB_WORDS; g++) begin : g_word
    logic         hit;
    logic [W-1:0] q;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data_i;
    end
    assign words[g] = q;
  end

  assign info_o   = words[W_INFO];
  assign src_o    = words[W_SRC];
  assign dst_o    = words[W_DST];
  assign len_o    = words[W_LEN];
  assign stride_o = words[W_STRIDE];
  assign next_o   = words[W_NEXT];
  assign flags_o  = decode_info(words[W_INFO]);

  // R1: only the six block slots are ever written
  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> (int'(wr_idx_i) < CB_WORDS));
endmodule

// File: rtl/cbdma_walker.sv
module cbdma_walker
  import cbdma_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int ROW_W = 14,
  parameter int XB_W  = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         word_step_i,
  input  logic         row_step_i,
  input  logic         rect_i,
  input  logic         src_adv_i,
  input  logic         dst_adv_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] len_i,
  input  logic [W-1:0] stride_i,
  output logic [W-1:0] src_o,
  output logic [W-1:0] dst_o,
  output logic [W-1:0] len_vis_o,
  output logic         row_has_word_o,
  output logic         rows_done_o
);
  localparam int       STRIDE_W = W / 2;
  localparam int       PAD_W    = W - XB_W - ROW_W;
  localparam logic [W-1:0] STEP = W'(4);

  logic [W-1:0]     src_q, src_d, dst_q, dst_d, len_q, len_d;
  logic [W-1:0]     xrem_q, xrem_d, rb_q, rb_d;
  logic [ROW_W-1:0] yrem_q, yrem_d;
  logic [W-1:0]     s_stride, d_stride;
  logic             en;

  assign s_stride = {{(W-STRIDE_W){stride_i[STRIDE_W-1]}}, stride_i[STRIDE_W-1:0]};
  assign d_stride = {{(W-STRIDE_W){stride_i[W-1]}}, stride_i[W-1:STRIDE_W]};
  assign en       = load_i | word_step_i | row_step_i;

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    len_d  = len_q;
    xrem_d = xrem_q;
    rb_d   = rb_q;
    yrem_d = yrem_q;
    if (load_i) begin
      src_d = src_i;
      dst_d = dst_i;
      len_d = len_i;
      if (rect_i) begin
        yrem_d = len_i[XB_W+ROW_W-1:XB_W];
        rb_d   = {{(W-XB_W){1'b0}}, len_i[XB_W-1:0]};
      end else begin
        yrem_d = ROW_W'(1);
        rb_d   = len_i;
      end
      xrem_d = rb_d;
    end else if (word_step_i) begin
      if (src_adv_i) src_d = src_q + STEP;
      if (dst_adv_i) dst_d = dst_q + STEP;
      xrem_d = xrem_q - STEP;
      if (rect_i) len_d = {{PAD_W{1'b0}}, yrem_q, xrem_d[XB_W-1:0]};
      else        len_d = xrem_d;
    end else if (row_step_i) begin
      yrem_d = yrem_q - ROW_W'(1);
      if (yrem_q != ROW_W'(1)) begin
        src_d = src_q + s_stride;
        dst_d = dst_q + d_stride;
      end
      xrem_d = rb_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      xrem_q <= '0;
      rb_q   <= '0;
      yrem_q <= '0;
    end else if (en) begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      len_q  <= len_d;
      xrem_q <= xrem_d;
      rb_q   <= rb_d;
      yrem_q <= yrem_d;
    end
  end

  assign src_o          = src_q;
  assign dst_o          = dst_q;
  assign len_vis_o      = len_q;
  assign row_has_word_o = (xrem_q >= STEP);
  assign rows_done_o    = (yrem_q == '0);

  // R6: a non-advancing side keeps its address across a word
  p_src_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_step_i && !src_adv_i) |=> (src_q == $past(src_q)));
  p_dst_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_step_i && !dst_adv_i) |=> (dst_q == $past(dst_q)));
  // R4: no stride after the last row
  p_last_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (row_step_i && yrem_q == ROW_W'(1)) |=> ($stable(src_q) && $stable(dst_q)));
  // R3: a word step never happens on an exhausted row
  p_word_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_step_i |-> (xrem_q >= STEP));
endmodule

// File: rtl/cbdma_engine.sv
module cbdma_engine
  import cbdma_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int ROW_W = 14,
  parameter int XB_W  = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] start_addr_i,
  input  logic         chan_en_i,
  output logic         mem_req_o,
  output logic         mem_we_o,
  output logic [W-1:0] mem_addr_o,
  output logic [W-1:0] mem_wdata_o,
  input  logic         mem_gnt_i,
  input  logic         mem_rvalid_i,
  input  logic [W-1:0] mem_rdata_i,
  output logic         busy_o,
  output logic         blk_done_o,
  output logic         blk_irq_o,
  output logic         chain_done_o,
  output logic [W-1:0] cur_blk_o,
  output logic [W-1:0] cur_info_o,
  output logic [W-1:0] cur_src_o,
  output logic [W-1:0] cur_dst_o,
  output logic [W-1:0] cur_len_o,
  output logic [W-1:0] cur_stride_o,
  output logic [W-1:0] cur_next_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CB_WORDS - 1);

  eng_state_t       state_q, state_d;
  logic [IDX_W-1:0] fidx_q, fidx_d;
  logic [W-1:0]     blk_q, blk_d, data_q, data_d;
  logic             cb_wr, load, wstep, rstep;
  logic [W-1:0]     cb_src, cb_dst, cb_len, cb_next;
  logic             row_has_word, rows_done;
  xinfo_t           flags;

  cbdma_cb_store #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(cb_wr), .wr_idx_i(fidx_q), .wr_data_i(mem_rdata_i),
    .info_o(cur_info_o), .src_o(cb_src), .dst_o(cb_dst), .len_o(cb_len),
    .stride_o(cur_stride_o), .next_o(cb_next), .flags_o(flags)
  );

  cbdma_walker #(.W(W), .ROW_W(ROW_W), .XB_W(XB_W)) u_walker (
    .clk(clk), .rst_n(rst_n),
    .load_i(load), .word_step_i(wstep), .row_step_i(rstep),
    .rect_i(flags.rect), .src_adv_i(flags.src_adv), .dst_adv_i(flags.dst_adv),
    .src_i(cb_src), .dst_i(cb_dst), .len_i(cb_len), .stride_i(cur_stride_o),
    .src_o(cur_src_o), .dst_o(cur_dst_o), .len_vis_o(cur_len_o),
    .row_has_word_o(row_has_word), .rows_done_o(rows_done)
  );

  always_comb begin
    state_d      = state_q;
    fidx_d       = fidx_q;
    blk_d        = blk_q;
    data_d       = data_q;
    mem_req_o    = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = '0;
    mem_wdata_o  = '0;
    cb_wr        = 1'b0;
    load         = 1'b0;
    wstep        = 1'b0;
    rstep        = 1'b0;
    blk_done_o   = 1'b0;
    chain_done_o = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        blk_d   = start_addr_i;
        state_d = S_CHECK;
      end
      S_CHECK: if (chan_en_i && (blk_q != '0)) begin
        fidx_d  = '0;
        state_d = S_FREQ;
      end else begin
        chain_done_o = 1'b1;
        state_d      = S_IDLE;
      end
      S_FREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = blk_q + {{(W-IDX_W-2){1'b0}}, fidx_q, 2'b00};
        if (mem_gnt_i) state_d = S_FWAIT;
      end
      S_FWAIT: if (mem_rvalid_i) begin
        cb_wr = 1'b1;
        if (fidx_q == LAST_IDX) state_d = S_SETUP;
        else begin
          fidx_d  = fidx_q + IDX_W'(1);
          state_d = S_FREQ;
        end
      end
      S_SETUP: begin
        load    = 1'b1;
        state_d = S_ROW;
      end
      S_ROW: begin
        if (rows_done) state_d = S_BEND;
        else if (row_has_word) begin
          if (flags.src_skip) begin
            data_d  = '0;
            state_d = S_WREQ;
          end else state_d = S_RREQ;
        end else rstep = 1'b1;
      end
      S_RREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_src_o;
        if (mem_gnt_i) state_d = S_RWAIT;
      end
      S_RWAIT: if (mem_rvalid_i) begin
        data_d  = mem_rdata_i;
        state_d = S_WREQ;
      end
      S_WREQ: begin
        if (flags.dst_skip) state_d = S_STEP;
        else begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = cur_dst_o;
          mem_wdata_o = data_q;
          if (mem_gnt_i) state_d = S_STEP;
        end
      end
      S_STEP: begin
        wstep   = 1'b1;
        state_d = S_ROW;
      end
      S_BEND: begin
        blk_done_o = 1'b1;
        blk_d      = cb_next;
        state_d    = S_CHECK;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      fidx_q  <= '0;
      blk_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      fidx_q  <= fidx_d;
      blk_q   <= blk_d;
      data_q  <= data_d;
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign blk_irq_o  = blk_done_o && flags.notify;
  assign cur_blk_o  = blk_q;
  assign cur_next_o = cb_next;

  // R1: a waiting request holds steady until granted
  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R5: skip flags suppress the corresponding access
  p_no_write_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> !flags.dst_skip);
  p_no_read_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RREQ) |-> !flags.src_skip);
  // R8: notify pulse only with a block completion
  p_irq_in_blk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blk_irq_o |-> blk_done_o);
  // R9: chain end leaves the engine idle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done_o |=> !busy_o);
endmodule

// File: tb/cbdma_engine_bench.sv
`timescale 1ns/1ps
module cbdma_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_addr_i = '0;
  logic        chan_en_i = 1'b1;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_gnt_i, mem_rvalid_i;
  logic [31:0] mem_rdata_i;
  logic        busy_o, blk_done_o, blk_irq_o, chain_done_o;
  logic [31:0] cur_blk_o, cur_info_o, cur_src_o, cur_dst_o, cur_len_o, cur_stride_o, cur_next_o;

  always #2.5 clk = ~clk;

  cbdma_engine u_cbdma_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .chan_en_i(chan_en_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_gnt_i(mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
    .blk_done_o(blk_done_o), .blk_irq_o(blk_irq_o), .chain_done_o(chain_done_o),
    .cur_blk_o(cur_blk_o), .cur_info_o(cur_info_o), .cur_src_o(cur_src_o),
    .cur_dst_o(cur_dst_o), .cur_len_o(cur_len_o), .cur_stride_o(cur_stride_o),
    .cur_next_o(cur_next_o)
  );

  // ---------------- memory model (256 words, address bits [9:2]) ----------
  logic [31:0] mem   [256];
  logic [31:0] exp_m [256];
  logic [7:0]  lfsr;
  logic        pend;
  logic [31:0] pdata;
  int n_req, n_wr, n_blk, n_irq, n_chain;
  int n_chk = 0, n_fail = 0, cyc = 0;

  assign mem_gnt_i    = lfsr[0] | lfsr[3];
  assign mem_rvalid_i = pend & (lfsr[1] | lfsr[4]);
  assign mem_rdata_i  = pdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= 8'h5A;
      pend <= 1'b0;
      pdata <= '0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (mem_rvalid_i) pend <= 1'b0;
      if (mem_req_o && mem_gnt_i) begin
        n_req = n_req + 1;
        if (mem_we_o) begin
          mem[mem_addr_o[9:2]] = mem_wdata_o;
          n_wr = n_wr + 1;
        end else begin
          pend  <= 1'b1;
          pdata <= mem[mem_addr_o[9:2]];
        end
      end
      if (blk_done_o)   n_blk = n_blk + 1;
      if (blk_irq_o)    n_irq = n_irq + 1;
      if (chain_done_o) n_chain = n_chain + 1;
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 190000) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
      $finish;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_chk = n_chk + 1;
    if (act !== expv) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", rq, act, expv);
    end
  endtask

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic fill_mem(input logic [31:0] seed);
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101) ^ seed;
  endtask

  task automatic put_cb(input logic [31:0] a, input logic [31:0] info, src, dst, len, stride, nxt);
    mem[a[9:2]]     = info;
    mem[a[9:2] + 1] = src;
    mem[a[9:2] + 2] = dst;
    mem[a[9:2] + 3] = len;
    mem[a[9:2] + 4] = stride;
    mem[a[9:2] + 5] = nxt;
  endtask

  // Reference model from the requirements, acting on exp_m.
  int          e_blk, e_irq, e_req;
  logic [31:0] e_src, e_dst, e_len, e_cur;
  task automatic model(input logic [31:0] start, input int maxblk);
    logic [31:0] a, info, s, d, len, str, nxt, xr, rb, dat;
    int rows;
    e_blk = 0; e_irq = 0; e_req = 0;
    a = start;
    while (a != 0 && e_blk < maxblk) begin
      info = exp_m[a[9:2]];     s   = exp_m[a[9:2] + 1];
      d    = exp_m[a[9:2] + 2]; len = exp_m[a[9:2] + 3];
      str  = exp_m[a[9:2] + 4]; nxt = exp_m[a[9:2] + 5];
      e_req = e_req + 6;
      e_len = len;
      if (info[1]) begin rows = int'(len[29:16]); rb = {16'h0, len[15:0]}; end
      else begin rows = 1; rb = len; end
      for (int r = 0; r < rows; r++) begin
        xr = rb;
        while (xr >= 4) begin
          if (info[11]) dat = 0;
          else begin dat = exp_m[s[9:2]]; e_req = e_req + 1; end
          if (!info[7]) begin exp_m[d[9:2]] = dat; e_req = e_req + 1; end
          if (info[8]) s = s + 4;
          if (info[4]) d = d + 4;
          xr = xr - 4;
          e_len = info[1] ? {2'b00, 14'(rows - r), xr[15:0]} : xr;
        end
        if (r != rows - 1) begin s = s + sx16(str[15:0]); d = d + sx16(str[31:16]); end
      end
      e_src = s; e_dst = d;
      e_blk = e_blk + 1;
      if (info[0]) e_irq = e_irq + 1;
      a = nxt;
    end
    e_cur = a;
  endtask

  // Run a chain; poke = start again while busy, drop = drop enable after first write.
  task automatic run(input logic [31:0] start, input int maxblk, input bit poke, input bit drop,
                     input bit cmp_live, input string rq);
    int c0, t, mism;
    for (int i = 0; i < 256; i++) exp_m[i] = mem[i];
    model(start, maxblk);
    n_req = 0; n_wr = 0; n_blk = 0; n_irq = 0;
    c0 = n_chain;
    @(negedge clk);
    start_addr_i = start; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t = 0;
    while (n_chain == c0 && t < 20000) begin
      if (poke && t == 20) begin start_addr_i = 32'h360; start_i = 1'b1; end
      else start_i = 1'b0;
      if (drop && n_wr > 0) chan_en_i = 1'b0;
      @(negedge clk);
      t++;
    end
    start_i = 1'b0;
    check({rq, " chain end"}, 32'(n_chain - c0), 32'd1);
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_m[i]) mism++;
    check({rq, " memory image"}, 32'(mism), 32'd0);
    check("R8 block count", 32'(n_blk), 32'(e_blk));
    check("R8 notify count", 32'(n_irq), 32'(e_irq));
    check("R1 request count", 32'(n_req), 32'(e_req));
    check("R8 current block", cur_blk_o, e_cur);
    if (cmp_live) begin
      check("R6 source address", cur_src_o, e_src);
      check("R6 destination address", cur_dst_o, e_dst);
      check("R7 visible length", cur_len_o, e_len);
    end
    check("R9 idle after chain", {31'b0, busy_o}, 32'd0);
    chan_en_i = 1'b1;
  endtask

  initial begin
    n_req = 0; n_wr = 0; n_blk = 0; n_irq = 0; n_chain = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 busy", {31'b0, busy_o}, 32'd0);
    check("R11 request", {31'b0, mem_req_o}, 32'd0);
    check("R11 block addr", cur_blk_o, 32'd0);
    check("R11 length", cur_len_o, 32'd0);
    check("R11 source", cur_src_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R5 R6: linear sweep of advance/skip flags
    for (int f = 0; f < 16; f++) begin
      logic [31:0] info;
      fill_mem(32'(f) * 32'h1357);
      info = (32'(f & 1) << 8) | (32'((f >> 1) & 1) << 4) | (32'((f >> 2) & 1) << 11)
           | (32'((f >> 3) & 1) << 7) | 32'((f & 1) ^ ((f >> 3) & 1));
      put_cb(32'h300, info, 32'h040, 32'h140, 32'd16, 32'h0, 32'h0);
      run(32'h300, 99, 1'b0, 1'b0, 1'b1, "R5");
    end

    // R4 R7: rectangle sweep over row counts and stride signs
    for (int rws = 0; rws < 4; rws++) begin
      for (int sel = 0; sel < 2; sel++) begin
        fill_mem(32'hC0DE + 32'(rws * 7 + sel));
        put_cb(32'h300, 32'h0000_0113, 32'h080, 32'h200, {2'b00, 14'(rws), 16'd12},
               sel == 0 ? 32'h0008_0004 : 32'hFFE4_FFF0, 32'h0);
        run(32'h300, 99, 1'b0, 1'b0, 1'b1, "R4");
      end
    end

    // R3 R8 R10: three-block chain, remainder length, start poked while busy
    fill_mem(32'h7777);
    put_cb(32'h300, 32'h0000_0110, 32'h000, 32'h180, 32'd18, 32'h0, 32'h320);
    put_cb(32'h320, 32'h0000_0113, 32'h020, 32'h1C0, {16'd2, 16'd8}, 32'hFFFC_0008, 32'h340);
    put_cb(32'h340, 32'h0000_0100, 32'h010, 32'h1F0, 32'd12, 32'h0, 32'h0);
    put_cb(32'h360, 32'h0000_0110, 32'h000, 32'h280, 32'd4, 32'h0, 32'h0);
    run(32'h300, 99, 1'b1, 1'b0, 1'b1, "R10 busy start");

    // R9: enable drops during first block; it finishes, the next is not fetched
    fill_mem(32'h4242);
    put_cb(32'h300, 32'h0000_0110, 32'h000, 32'h180, 32'd32, 32'h0, 32'h320);
    put_cb(32'h320, 32'h0000_0110, 32'h040, 32'h2C0, 32'd8, 32'h0, 32'h0);
    run(32'h300, 1, 1'b0, 1'b1, 1'b1, "R9");

    // R10: enable low at start, and zero start address
    fill_mem(32'h1111);
    put_cb(32'h300, 32'h0000_0110, 32'h000, 32'h180, 32'd8, 32'h0, 32'h0);
    chan_en_i = 1'b0;
    run(32'h300, 0, 1'b0, 1'b0, 1'b0, "R10 disabled");
    run(32'h000, 99, 1'b0, 1'b0, 1'b0, "R10 zero address");

    report();
    $finish;
  end
endmodule